// File: doc/BRIEF.md
# ADC Serial Link Power Sequencer

This block is the host side of a 16-clock serial link to a low-power sampling ADC. Each conversion frame pulls chip select low and runs sixteen serial clocks. During the first eight clocks it sends a control byte that includes a two-bit power-mode field. Across all sixteen clocks it collects the 16-bit conversion result. The serial clock is divided down from the system clock.

The block keeps a model of whether the converter is powered. If a start arrives while the converter is asleep, the block first runs a discarded wake-up frame. That frame programs the always-on mode and stretches the time between the first falling serial edge and the sampling edge by a programmable power-up hold. After a short chip-select-high gap, the block runs the real frame with the requested mode. If the converter is already awake, only the real frame runs, with no hold.

A user requests a conversion with a single-cycle start strobe and a mode code. The user then waits for the busy flag to drop. At the end of the real frame the result appears, together with a one-cycle valid pulse.

Top module: `adc_pwr_seq`

## Requirements
- R1: While reset is applied and after it is released, cs_n and sclk are high, din is low, busy and res_valid are low, and result is zero.
- R2: A frame starts when cs_n falls and contains exactly 16 sclk cycles, each a fall followed by a rise. sclk stays high whenever cs_n is high.
- R3: The control byte goes out MSB first. din changes only on sclk falls or when cs_n falls. Byte bits [7:6] carry the mode code and bits [5:0] the CTRL_LOW parameter. din is low for sclk rises 9 to 16.
- R4: Mode codes are 2'b00 (sleeps when cs_n rises), 2'b01 (always on) and 2'b10 (sleeps after every conversion). Code 2'b11 is sent as 2'b01.
- R5: After reset, and after a real frame sent with mode 2'b00 or 2'b10, the converter counts as asleep. A start in that case runs a wake-up frame that sends mode 2'b01 and discards its result, then a real frame that sends the requested mode. A start to an awake converter runs only the real frame.
- R6: In a wake-up frame, the first sclk fall and the second sclk rise are 3*HALF_DIV+PWRUP_CYC clock cycles apart. In a real frame they are 3*HALF_DIV cycles apart.
- R7: dout is sampled on sclk rises, MSB first. At the end of the real frame, result takes the 16 sampled bits and res_valid pulses for one cycle, in the same cycle that cs_n rises. result holds between pulses.
- R8: busy rises in the cycle after an accepted start and falls in the cycle that cs_n rises at the end of the real frame. A start while busy is ignored.
- R9: Between the wake-up frame and the real frame, cs_n stays high for QUIET_CYC clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle conversion request |
| req_mode | input | 2 | Requested power mode code |
| busy | output | 1 | Conversion sequence in progress |
| result | output | FRAME_BITS | Last valid conversion result |
| res_valid | output | 1 | One-cycle pulse when result updates |
| adc_cs_n | output | 1 | Active-low chip select to the converter |
| adc_sclk | output | 1 | Serial clock, idles high |
| adc_din | output | 1 | Serial control data to the converter |
| adc_dout | input | 1 | Serial result data from the converter |

## Verification
The assertions assume that start is one cycle wide and that req_mode matters only in the cycle start is accepted. They also assume that adc_dout is settled by each sclk rise; the sequencer does not check this. The stimulus meets these assumptions: it changes start, req_mode and rst_n only on falling system-clock edges. The converter model changes dout only on chip-select and serial-clock falls, so dout is stable well before every rise. One directed run deliberately raises start while busy, to show that the sequencer ignores it.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LEAD,
    S_LOW,
    S_HIGH,
    S_HOLD,
    S_TAIL,
    S_GAP
  } seq_state_t;

  localparam logic [1:0] PM_CSREL = 2'b00;
  localparam logic [1:0] PM_ON    = 2'b01;
  localparam logic [1:0] PM_AUTO  = 2'b10;

  // Reserved code 2'b11 is mapped onto always-on.
  function automatic logic [1:0] pm_legal(input logic [1:0] m);
    return (m == 2'b11) ? PM_ON : m;
  endfunction

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [CW-1:0] limit,
  output logic          done
);

  logic [CW-1:0] cnt_q, cnt_d;

  assign done = (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clear)      cnt_d = '0;
    else if (!done) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/adc_seq_shift.sv
module adc_seq_shift #(
  parameter int CTRL_BITS  = 8,
  parameter int FRAME_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [CTRL_BITS-1:0]  word,
  input  logic                  fall_en,
  input  logic                  rise_en,
  input  logic                  dout,
  output logic                  din,
  output logic [FRAME_BITS-1:0] capture
);

  logic [CTRL_BITS-1:0]  tx_q, tx_d;
  logic                  din_q, din_d;
  logic [FRAME_BITS-1:0] rx_q, rx_d;

  always_comb begin
    tx_d  = tx_q;
    din_d = din_q;
    rx_d  = rx_q;
    if (load) begin
      tx_d  = word;
      din_d = 1'b0;
    end else if (fall_en) begin
      // Zeros shift in behind the byte, so din is low after the 8th fall.
      din_d = tx_q[CTRL_BITS-1];
      tx_d  = {tx_q[CTRL_BITS-2:0], 1'b0};
    end
    if (rise_en) rx_d = {rx_q[FRAME_BITS-2:0], dout};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      din_q <= 1'b0;
      rx_q  <= '0;
    end else begin
      tx_q  <= tx_d;
      din_q <= din_d;
      rx_q  <= rx_d;
    end
  end

  assign din     = din_q;
  assign capture = rx_q;

endmodule

// File: rtl/adc_seq_awake.sv
module adc_seq_awake
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_end,
  input  logic       was_wake,
  input  logic [1:0] pm_sent,
  output logic       awake
);

  logic awake_q, awake_d;

  always_comb begin
    awake_d = awake_q;
    if (frame_end) awake_d = was_wake ? 1'b1 : (pm_sent == PM_ON);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) awake_q <= 1'b0;
    else        awake_q <= awake_d;
  end

  assign awake = awake_q;

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_seq_pkg::*;
#(
  parameter int          FRAME_BITS = 16,
  parameter int          CTRL_BITS  = 8,
  parameter int          HALF_DIV   = 2,
  parameter int          PWRUP_CYC  = 625,
  parameter int          QUIET_CYC  = 4,
  parameter logic [5:0]  CTRL_LOW   = 6'b000000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [1:0]            req_mode,
  output logic                  busy,
  output logic [FRAME_BITS-1:0] result,
  output logic                  res_valid,
  output logic                  adc_cs_n,
  output logic                  adc_sclk,
  output logic                  adc_din,
  input  logic                  adc_dout
);

  localparam int LIM_A   = (HALF_DIV > QUIET_CYC) ? HALF_DIV : QUIET_CYC;
  localparam int LIM_MAX = (PWRUP_CYC > LIM_A) ? PWRUP_CYC : LIM_A;
  localparam int CW      = $clog2(LIM_MAX + 1);
  localparam int BW      = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rs_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  seq_state_t            state_q, state_d;
  logic                  cs_q, cs_d;
  logic                  sclk_q, sclk_d;
  logic [BW-1:0]         bit_q, bit_d;
  logic                  wake_q, wake_d;
  logic [1:0]            pm_q, pm_d;
  logic                  vld_q, vld_d;
  logic [FRAME_BITS-1:0] res_q, res_d;

  logic                  tdone, tclear;
  logic [CW-1:0]         tlim;
  logic                  fall_en, rise_en, frame_end, load;
  logic                  awake;
  logic [CTRL_BITS-1:0]  word;
  logic [FRAME_BITS-1:0] capture;

  always_comb begin
    case (state_q)
      S_HOLD:  tlim = CW'(PWRUP_CYC - 1);
      S_GAP:   tlim = CW'(QUIET_CYC - 1);
      default: tlim = CW'(HALF_DIV - 1);
    endcase
  end

  always_comb begin
    state_d   = state_q;
    cs_d      = cs_q;
    sclk_d    = sclk_q;
    bit_d     = bit_q;
    wake_d    = wake_q;
    pm_d      = pm_q;
    vld_d     = 1'b0;
    res_d     = res_q;
    fall_en   = 1'b0;
    rise_en   = 1'b0;
    frame_end = 1'b0;
    case (state_q)
      S_IDLE: if (start) begin
        state_d = S_LEAD;
        cs_d    = 1'b0;
        bit_d   = '0;
        wake_d  = ~awake;
        pm_d    = pm_legal(req_mode);
      end
      S_LEAD, S_HIGH: if (tdone) begin
        state_d = S_LOW;
        sclk_d  = 1'b0;
        fall_en = 1'b1;
      end
      S_LOW: if (tdone) begin
        rise_en = 1'b1;
        sclk_d  = 1'b1;
        bit_d   = bit_q + 1'b1;
        if (bit_q == LAST_BIT)          state_d = S_TAIL;
        else if (wake_q && bit_q == '0) state_d = S_HOLD;
        else                            state_d = S_HIGH;
      end
      S_HOLD: if (tdone) state_d = S_HIGH;
      S_TAIL: if (tdone) begin
        frame_end = 1'b1;
        cs_d      = 1'b1;
        wake_d    = 1'b0;
        if (wake_q) begin
          state_d = S_GAP;
        end else begin
          state_d = S_IDLE;
          vld_d   = 1'b1;
          res_d   = capture;
        end
      end
      S_GAP: if (tdone) begin
        state_d = S_LEAD;
        cs_d    = 1'b0;
        bit_d   = '0;
      end
      default: state_d = S_IDLE;
    endcase
  end

  assign tclear = (state_d != state_q) || (state_q == S_IDLE);
  assign load   = (state_d == S_LEAD) && (state_q != S_LEAD);
  assign word   = {(wake_d ? PM_ON : pm_d), CTRL_LOW};

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= S_IDLE;
      cs_q    <= 1'b1;
      sclk_q  <= 1'b1;
      bit_q   <= '0;
      wake_q  <= 1'b0;
      pm_q    <= PM_ON;
      vld_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      cs_q    <= cs_d;
      sclk_q  <= sclk_d;
      bit_q   <= bit_d;
      wake_q  <= wake_d;
      pm_q    <= pm_d;
      vld_q   <= vld_d;
      res_q   <= res_d;
    end
  end

  adc_seq_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clear (tclear),
    .limit (tlim),
    .done  (tdone)
  );

  adc_seq_shift #(.CTRL_BITS(CTRL_BITS), .FRAME_BITS(FRAME_BITS)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load    (load),
    .word    (word),
    .fall_en (fall_en),
    .rise_en (rise_en),
    .dout    (adc_dout),
    .din     (adc_din),
    .capture (capture)
  );

  adc_seq_awake u_awake (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .frame_end (frame_end),
    .was_wake  (wake_q),
    .pm_sent   (pm_q),
    .awake     (awake)
  );

  assign busy      = (state_q != S_IDLE);
  assign result    = res_q;
  assign res_valid = vld_q;
  assign adc_cs_n  = cs_q;
  assign adc_sclk  = sclk_q;

endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk #(
  parameter int FRAME_BITS = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busy,
  input logic                  res_valid,
  input logic [FRAME_BITS-1:0] result,
  input logic                  adc_cs_n,
  input logic                  adc_sclk,
  input logic                  adc_din
);

  AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> adc_sclk); // R2

  AST_DIN_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(adc_din) |-> ($fell(adc_sclk) || $fell(adc_cs_n))); // R3

  AST_VALID_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $rose(adc_cs_n)); // R7

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R7

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(result)); // R7

  AST_CS_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cs_n |-> busy); // R8

  AST_BUSY_END_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $rose(adc_cs_n)); // R8

endmodule

bind adc_pwr_seq adc_pwr_seq_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .busy      (busy),
  .res_valid (res_valid),
  .result    (result),
  .adc_cs_n  (adc_cs_n),
  .adc_sclk  (adc_sclk),
  .adc_din   (adc_din)
);

// File: tb/sim_adc_pwr_seq.sv
`timescale 1ns/1ps
module sim_adc_pwr_seq;

  localparam int         HALF  = 2;
  localparam int         PWR   = 625;
  localparam int         QUIET = 4;
  localparam logic [5:0] LOWB  = 6'b101100;
  localparam int         WD    = 5000;

  // {req_mode, expected frame count, expected mode field of the real frame}
  localparam logic [5:0] VEC [8] = '{
    6'b01_10_01, 6'b01_01_01, 6'b10_01_10, 6'b10_10_10,
    6'b00_10_00, 6'b11_10_01, 6'b00_01_00, 6'b01_10_01
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  req_mode;
  logic        busy;
  logic [15:0] result;
  logic        res_valid;
  logic        adc_cs_n, adc_sclk, adc_din;
  logic        adc_dout;

  always #4 clk = ~clk;

  adc_pwr_seq #(
    .HALF_DIV(HALF), .PWRUP_CYC(PWR), .QUIET_CYC(QUIET), .CTRL_LOW(LOWB)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .req_mode(req_mode),
    .busy(busy), .result(result), .res_valid(res_valid),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_din(adc_din),
    .adc_dout(adc_dout)
  );

  int nchk = 0;
  int nerr = 0;

  // Converter model and frame records
  bit          mon_on = 1'b0;
  int          frame_no = 0;
  logic [15:0] cur_val;
  int          fidx, rcnt;
  logic [7:0]  cw;
  longint      t_fall0, t_rise1, t_csrise;
  int          nfr, span_first, span_last, bad_rises, bad_tail, gap_cyc, vcnt;
  logic [7:0]  cw_first, cw_last;
  logic [15:0] vres;

  function automatic logic [15:0] adc_val(input int n);
    return 16'h3C5A + 16'(n * 2833);
  endfunction

  always @(negedge adc_cs_n) if (mon_on) begin
    cur_val = adc_val(frame_no);
    frame_no++;
    fidx = 0;
    rcnt = 0;
    cw = 8'h00;
    adc_dout = cur_val[15];
    if (nfr > 0) gap_cyc = int'(($time - t_csrise) / 8);
  end

  always @(negedge adc_sclk) if (mon_on && !adc_cs_n) begin
    if (fidx == 0) t_fall0 = $time;
    else if (fidx < 16) adc_dout = cur_val[15 - fidx];
    fidx++;
  end

  always @(posedge adc_sclk) if (mon_on && !adc_cs_n) begin
    if (rcnt < 8) cw = {cw[6:0], adc_din};
    else if (adc_din) bad_tail++;
    if (rcnt == 1) t_rise1 = $time;
    rcnt++;
  end

  always @(posedge adc_cs_n) if (mon_on) begin
    t_csrise = $time;
    if (nfr == 0) begin
      cw_first   = cw;
      span_first = int'((t_rise1 - t_fall0) / 8);
    end
    cw_last   = cw;
    span_last = int'((t_rise1 - t_fall0) / 8);
    if (rcnt != 16) bad_rises++;
    nfr++;
  end

  always @(negedge clk) if (mon_on && res_valid) begin
    vcnt++;
    vres = result;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_rec();
    nfr = 0; span_first = 0; span_last = 0; bad_rises = 0; bad_tail = 0;
    gap_cyc = 0; vcnt = 0; vres = 16'h0; cw_first = 8'h0; cw_last = 8'h0;
  endtask

  task automatic run_start(input logic [1:0] m, input bit poke);
    int cyc;
    clear_rec();
    @(negedge clk);
    start = 1'b1;
    req_mode = m;
    @(negedge clk);
    start = 1'b0;
    chk("R8", "busy after start", 32'(busy), 32'd1);
    cyc = 0;
    while (busy && cyc < WD) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 40) begin
        start = 1'b1;
        req_mode = ~m;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    if (cyc >= WD) begin
      nchk++;
      nerr++;
      $display("FAIL R8 watchdog: actual=busy expected=idle");
    end
    chk("R8", "cs_n when busy drops", 32'(adc_cs_n), 32'd1);
    chk("R7", "valid when busy drops", 32'(res_valid), 32'd1);
    @(negedge clk);
    chk("R7", "valid pulse width", 32'(res_valid), 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    req_mode = 2'b01;
    adc_dout = 1'b0;
    clear_rec();
    repeat (3) @(negedge clk);
    // R1: outputs while reset is held
    chk("R1", "cs_n in reset", 32'(adc_cs_n), 32'd1);
    chk("R1", "sclk in reset", 32'(adc_sclk), 32'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;
    chk("R1", "din after reset", 32'(adc_din), 32'd0);
    chk("R1", "busy after reset", 32'(busy), 32'd0);
    chk("R1", "valid after reset", 32'(res_valid), 32'd0);
    chk("R1", "result after reset", 32'(result), 32'd0);

    for (int i = 0; i < 8; i++) begin
      logic [1:0] m, pm;
      int         nf;
      m  = VEC[i][5:4];
      nf = int'(VEC[i][3:2]);
      pm = VEC[i][1:0];
      run_start(m, 1'b0);
      chk("R5", "frame count", 32'(nfr), 32'(nf));
      chk("R4", "mode field of real frame", 32'(cw_last[7:6]), 32'(pm));
      chk("R3", "low control bits", 32'(cw_last[5:0]), 32'(LOWB));
      chk("R3", "din low after byte", 32'(bad_tail), 32'd0);
      chk("R2", "frames with 16 rises", 32'(bad_rises), 32'd0);
      chk("R6", "real frame fall0-rise1", 32'(span_last), 32'(3 * HALF));
      chk("R7", "valid pulse count", 32'(vcnt), 32'd1);
      chk("R7", "result value", 32'(vres), 32'(adc_val(frame_no - 1)));
      if (nf == 2) begin
        chk("R5", "wake frame mode field", 32'(cw_first[7:6]), 32'd1);
        chk("R6", "wake frame hold", 32'(span_first), 32'(3 * HALF + PWR));
        chk("R9", "cs_n high gap", 32'(gap_cyc), 32'(QUIET));
      end
    end

    // R8: start while busy is ignored (converter is awake here)
    run_start(2'b01, 1'b1);
    chk("R8", "frames with start while busy", 32'(nfr), 32'd1);
    chk("R8", "mode kept despite second start", 32'(cw_last[7:6]), 32'd1);
    chk("R8", "single valid with extra start", 32'(vcnt), 32'd1);
    repeat (20) @(negedge clk);
    chk("R8", "no extra sequence after ignored start", 32'(busy), 32'd0);

    // R1/R5: reset in the middle of a frame returns to idle and to asleep
    @(negedge clk);
    start = 1'b1;
    req_mode = 2'b01;
    @(negedge clk);
    start = 1'b0;
    repeat (15) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "cs_n after mid-frame reset", 32'(adc_cs_n), 32'd1);
    chk("R1", "sclk after mid-frame reset", 32'(adc_sclk), 32'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "busy after mid-frame reset", 32'(busy), 32'd0);
    run_start(2'b01, 1'b0);
    chk("R5", "wake needed after reset", 32'(nfr), 32'd2);
    chk("R7", "result after reset recovery", 32'(vres), 32'(adc_val(frame_no - 1)));

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule